// File: doc/BRIEF.md
# Programmable strobe timing generator

This block drives the control strobes of an asynchronous parallel display bus: a chip select, a write strobe, a read strobe and a command/data select line. Every access is measured in ticks from its own start. Each strobe edge, the length of a write or read access, the point at which read data is captured, and the minimum idle time of the chip select between two accesses all come from programmable tick counts held in two packed timing words.

Software, or a sequencer in front of the block, loads the timing words once. The block checks them against the ordering rules of the bus. A word set that breaks a rule is refused and a sticky error flag is raised. After that, each start pulse runs one access, either a read or a write, with a given command/data select level. A start that arrives while an access or the idle gap is still running is kept and launched as soon as the gap ends. A half-rate bit stretches every tick to two clock periods, and four inversion bits set the active level of each bus line.

Top module: `strobe_timing_gen`

## Requirements
- R1: While reset is applied, and after it ends until the first load and start, every bus pin, `sample_o`, `done_o`, `cfg_err` and `rd_data` are 0.
- R2: A write access makes CS active for ticks t with cs_on <= t < cs_off and WE active for we_on <= t < we_off. RE stays inactive. The access lasts write-cycle ticks, so CS is cut off at the end of the access. `done_o` is high for exactly one clock, the last clock of the final tick. On the pins, tick 0 starts one clock after the edge that accepts the start.
- R3: A read access makes CS active as in R2 and RE active for re_on <= t < re_off. WE stays inactive. The access lasts read-cycle ticks. `sample_o` pulses for one clock on the first clock of tick access-time, and `rd_data` holds the `bus_din` value present at that clock from the same edge onward.
- R4: With `cfg_half_rate` = 1, every tick lasts two clocks. This holds for the strobe windows, the access length and the CS idle gap.
- R5: `cfg_invert` bit 0 inverts CS, bit 1 inverts WE, bit 2 inverts RE and bit 3 inverts the command/data pin. The inversion applies in idle as well as during accesses.
- R6: `dc_o` takes the `op_dc` value of an access one clock after that access is accepted, and holds it until the next access is accepted.
- R7: After an access ends, the next access is accepted no sooner than gap*T+1 clocks after its final edge, where gap is the CS pulse width in ticks and T is 1 or 2 clocks per tick.
- R8: A start that arrives during an access or the gap is held, with its own read/write and command/data values, and runs when the gap ends. A further start while one is already held is ignored.
- R9: A load whose words break an ordering rule (we_off > we_on, re_off > re_on, cs_off > cs_on, cs_off >= we_off, cs_off >= re_off, read cycle >= re_off, write cycle >= we_off, access time > re_on), or that has a nonzero bit in cycle-word bits 21:18, changes no setting and sets `cfg_err`. `cfg_err` stays set until reset, even across later legal loads.
- R10: The edge word holds cs_on in bits 3:0, cs_off in 9:4, we_on in 13:10, we_off in 19:14, re_on in 23:20 and re_off in 29:24. The cycle word holds the write cycle in bits 5:0, the read cycle in 11:6, the CS pulse width in 17:12 and the access time in 27:22. Every bit of each field is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | Load pulse for the timing words, rate bit and inversion bits |
| cfg_edges | input | 30 | Strobe on/off tick word |
| cfg_cycle | input | 28 | Cycle length, gap and access time word |
| cfg_half_rate | input | 1 | 1 selects a two-clock tick |
| cfg_invert | input | 4 | Per-line inversion: CS, WE, RE, command/data |
| cfg_err | output | 1 | Sticky flag for a refused load |
| start | input | 1 | Start of one access |
| op_read | input | 1 | 1 for a read access, 0 for a write access |
| op_dc | input | 1 | Command/data select level for the access |
| bus_din | input | DATA_W | Read data from the bus |
| cs_o | output | 1 | Chip select pin |
| we_o | output | 1 | Write strobe pin |
| re_o | output | 1 | Read strobe pin |
| dc_o | output | 1 | Command/data select pin |
| sample_o | output | 1 | One-clock strobe at the read capture point |
| done_o | output | 1 | One-clock pulse at the end of an access |
| rd_data | output | DATA_W | Captured read data |

## Verification
A start sampled on clock edge E puts tick 0 on the pins after edge E+1. From there, each pin value at clock k after the accepting edge reflects tick (k-1)/T. `done_o`, `sample_o` and `rd_data` change on the same edge as the pins for their tick, and `cfg_err` changes one edge after the load. The bench builds a table of expected pin levels for every clock of a scenario from the programmed tick counts, including accept points it derives from the gap rule. It samples the pins at each falling edge and compares every clock against that table. Held starts and refused loads are judged by the waveform that follows them.

// File: rtl/strobe_timing_gen.sv
module strobe_timing_gen #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [29:0]       cfg_edges,
  input  logic [27:0]       cfg_cycle,
  input  logic              cfg_half_rate,
  input  logic [3:0]        cfg_invert,
  output logic              cfg_err,
  input  logic              start,
  input  logic              op_read,
  input  logic              op_dc,
  input  logic [DATA_W-1:0] bus_din,
  output logic              cs_o,
  output logic              we_o,
  output logic              re_o,
  output logic              dc_o,
  output logic              sample_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rd_data
);

  function automatic logic cfg_ok(input logic [29:0] e, input logic [27:0] c);
    logic [5:0] cson, csoff, weon, weoff, reon, reoff, wcyc, rcyc, acc;
    cson  = {2'b00, e[3:0]};
    csoff = e[9:4];
    weon  = {2'b00, e[13:10]};
    weoff = e[19:14];
    reon  = {2'b00, e[23:20]};
    reoff = e[29:24];
    wcyc  = c[5:0];
    rcyc  = c[11:6];
    acc   = c[27:22];
    return (weoff > weon) && (reoff > reon) && (csoff > cson) &&
           (csoff >= weoff) && (csoff >= reoff) &&
           (rcyc >= reoff) && (wcyc >= weoff) && (acc > reon) &&
           (c[21:18] == 4'd0);
  endfunction

  logic [29:0] edges_q;
  logic [23:0] cyc_q;
  logic        half_q;
  logic [3:0]  inv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edges_q <= '0;
      cyc_q   <= '0;
      half_q  <= 1'b0;
      inv_q   <= '0;
      cfg_err <= 1'b0;
    end else if (cfg_load) begin
      if (cfg_ok(cfg_edges, cfg_cycle)) begin
        edges_q <= cfg_edges;
        cyc_q   <= {cfg_cycle[27:22], cfg_cycle[17:0]};
        half_q  <= cfg_half_rate;
        inv_q   <= cfg_invert;
      end else begin
        cfg_err <= 1'b1;
      end
    end
  end

  wire [5:0] cs_on  = {2'b00, edges_q[3:0]};
  wire [5:0] cs_off = edges_q[9:4];
  wire [5:0] we_on  = {2'b00, edges_q[13:10]};
  wire [5:0] we_off = edges_q[19:14];
  wire [5:0] re_on  = {2'b00, edges_q[23:20]};
  wire [5:0] re_off = edges_q[29:24];
  wire [5:0] wr_cyc = cyc_q[5:0];
  wire [5:0] rd_cyc = cyc_q[11:6];
  wire [5:0] gap_w  = cyc_q[17:12];
  wire [5:0] acc_t  = cyc_q[23:18];

  logic       active, phase, rd_q, dc_q, pend, pend_rd, pend_dc;
  logic [5:0] cnt, gap;

  wire       tick    = ~half_q | phase;
  wire [5:0] cyc_len = rd_q ? rd_cyc : wr_cyc;
  wire       last    = active & tick & (({1'b0, cnt} + 7'd1) >= {1'b0, cyc_len});
  wire       go      = ~active & (gap == 6'd0) & (pend | start);

  wire lvl_cs  = active & (cnt >= cs_on) & (cnt < cs_off);
  wire lvl_we  = active & ~rd_q & (cnt >= we_on) & (cnt < we_off);
  wire lvl_re  = active & rd_q & (cnt >= re_on) & (cnt < re_off);
  wire lvl_smp = active & rd_q & (cnt == acc_t) & ~phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      phase   <= 1'b0;
      cnt     <= '0;
      gap     <= '0;
      rd_q    <= 1'b0;
      dc_q    <= 1'b0;
      pend    <= 1'b0;
      pend_rd <= 1'b0;
      pend_dc <= 1'b0;
    end else begin
      if (go) begin
        active <= 1'b1;
        cnt    <= '0;
        phase  <= 1'b0;
        rd_q   <= pend ? pend_rd : op_read;
        dc_q   <= pend ? pend_dc : op_dc;
      end else if (last) begin
        active <= 1'b0;
        phase  <= 1'b0;
        gap    <= gap_w;
      end else begin
        phase <= half_q & ~phase;
        if (active && tick) cnt <= cnt + 6'd1;
        if (!active && tick && gap != 6'd0) gap <= gap - 6'd1;
      end

      if (go) begin
        pend <= 1'b0;
      end else if (start && !pend) begin
        pend    <= 1'b1;
        pend_rd <= op_read;
        pend_dc <= op_dc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_o     <= 1'b0;
      we_o     <= 1'b0;
      re_o     <= 1'b0;
      dc_o     <= 1'b0;
      sample_o <= 1'b0;
      done_o   <= 1'b0;
      rd_data  <= '0;
    end else begin
      cs_o     <= lvl_cs ^ inv_q[0];
      we_o     <= lvl_we ^ inv_q[1];
      re_o     <= lvl_re ^ inv_q[2];
      dc_o     <= dc_q ^ inv_q[3];
      sample_o <= lvl_smp;
      done_o   <= last;
      if (lvl_smp) rd_data <= bus_din;
    end
  end

endmodule

// File: rtl/strobe_timing_gen_chk.sv
module strobe_timing_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_o,
  input logic        we_o,
  input logic        re_o,
  input logic        sample_o,
  input logic        done_o,
  input logic        cfg_err,
  input logic [3:0]  inv_q,
  input logic [29:0] edges_q,
  input logic [23:0] cyc_q
);

  assert_we_re_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !((we_o ^ $past(inv_q[1])) && (re_o ^ $past(inv_q[2]))));

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_sample_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |=> !sample_o);

  assert_cs_idle_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (cs_o == $past(inv_q[0])));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  assert_reject_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> ($stable(edges_q) && $stable(cyc_q)));

endmodule

bind strobe_timing_gen strobe_timing_gen_chk u_chk (.*);

// File: tb/sim_strobe_timing_gen.sv
module sim_strobe_timing_gen;
  localparam int DW   = 16;
  localparam int NMAX = 96;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0, cfg_load = 1'b0, cfg_half_rate = 1'b0;
  logic          start = 1'b0, op_read = 1'b0, op_dc = 1'b0;
  logic [29:0]   cfg_edges = '0;
  logic [27:0]   cfg_cycle = '0;
  logic [3:0]    cfg_invert = '0;
  logic [DW-1:0] bus_din = '0;
  logic          cfg_err, cs_o, we_o, re_o, dc_o, sample_o, done_o;
  logic [DW-1:0] rd_data;

  strobe_timing_gen #(.DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_edges(cfg_edges),
    .cfg_cycle(cfg_cycle), .cfg_half_rate(cfg_half_rate), .cfg_invert(cfg_invert),
    .cfg_err(cfg_err), .start(start), .op_read(op_read), .op_dc(op_dc),
    .bus_din(bus_din), .cs_o(cs_o), .we_o(we_o), .re_o(re_o), .dc_o(dc_o),
    .sample_o(sample_o), .done_o(done_o), .rd_data(rd_data)
  );

  int checks = 0, errors = 0;
  int t_cson, t_csoff, t_weon, t_weoff, t_reon, t_reoff, t_wcyc, t_rcyc, t_acc, t_T;
  logic [3:0] t_inv = '0;
  bit last_dc = 1'b0;

  bit [5:0]      e_lvl [NMAX];
  bit [5:0]      a_pin [NMAX];
  logic [DW-1:0] a_rd  [NMAX];
  bit            s_en  [NMAX];
  bit            s_rd  [NMAX];
  bit            s_dc  [NMAX];
  string         nm [6] = '{"cs_o", "we_o", "re_o", "dc_o", "sample_o", "done_o"};

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic load_raw(input logic [29:0] e, input logic [27:0] c, input bit half, input logic [3:0] inv);
    cfg_edges = e; cfg_cycle = c; cfg_half_rate = half; cfg_invert = inv; cfg_load = 1'b1;
    @(posedge clk); @(negedge clk);
    cfg_load = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic load(input int cson, input int csoff, input int weon, input int weoff,
                      input int reon, input int reoff, input int wcyc, input int rcyc,
                      input int csw, input int acc, input bit half, input logic [3:0] inv,
                      input bit legal);
    load_raw({6'(reoff), 4'(reon), 6'(weoff), 4'(weon), 6'(csoff), 4'(cson)},
             {6'(acc), 4'b0000, 6'(csw), 6'(rcyc), 6'(wcyc)}, half, inv);
    if (legal) begin
      t_cson = cson; t_csoff = csoff; t_weon = weon; t_weoff = weoff;
      t_reon = reon; t_reoff = reoff; t_wcyc = wcyc; t_rcyc = rcyc;
      t_acc = acc; t_T = half ? 2 : 1; t_inv = inv;
    end
  endtask

  task automatic clear_plan();
    for (int k = 0; k < NMAX; k++) begin
      e_lvl[k] = {3'b000, last_dc, 2'b00};
      s_en[k] = 1'b0; s_rd[k] = 1'b0; s_dc[k] = 1'b0;
    end
  endtask

  task automatic sched(input int k, input bit rd, input bit dc);
    s_en[k] = 1'b1; s_rd[k] = rd; s_dc[k] = dc;
  endtask

  task automatic add_acc(input int a, input bit rd, input bit dc);
    int cyc;
    cyc = rd ? t_rcyc : t_wcyc;
    for (int k = a + 1; k < NMAX; k++) begin
      int m, t;
      m = k - a - 1;
      t = m / t_T;
      e_lvl[k][2] = dc;
      if (m < cyc * t_T) begin
        e_lvl[k][5] = (t >= t_cson) && (t < t_csoff);
        e_lvl[k][4] = !rd && (t >= t_weon) && (t < t_weoff);
        e_lvl[k][3] = rd && (t >= t_reon) && (t < t_reoff);
        e_lvl[k][1] = rd && (t == t_acc) && ((m % t_T) == 0);
        e_lvl[k][0] = (m == cyc * t_T - 1);
      end else begin
        e_lvl[k][5] = 1'b0; e_lvl[k][4] = 1'b0; e_lvl[k][3] = 1'b0;
        e_lvl[k][1] = 1'b0; e_lvl[k][0] = 1'b0;
      end
    end
    last_dc = dc;
  endtask

  task automatic run(input int n, input string req, input logic [DW-1:0] din);
    bus_din = din;
    for (int k = 0; k < n; k++) begin
      start = s_en[k]; op_read = s_rd[k]; op_dc = s_dc[k];
      @(posedge clk); @(negedge clk);
      a_pin[k] = {cs_o, we_o, re_o, dc_o, sample_o, done_o};
      a_rd[k] = rd_data;
    end
    start = 1'b0;
    for (int b = 0; b < 6; b++) begin
      int bad;
      bit ev;
      bad = -1;
      for (int k = 0; k < n; k++) begin
        ev = e_lvl[k][5-b] ^ ((b < 4) ? t_inv[b] : 1'b0);
        if (bad < 0 && a_pin[k][5-b] !== ev) bad = k;
      end
      if (bad < 0) chk(req, nm[b], 32'd0, 32'd0);
      else begin
        ev = e_lvl[bad][5-b] ^ ((b < 4) ? t_inv[b] : 1'b0);
        chk(req, $sformatf("%s at clock %0d", nm[b], bad), 32'(a_pin[bad][5-b]), 32'(ev));
      end
    end
    for (int k = 0; k < n; k++)
      if (e_lvl[k][1]) chk(req, $sformatf("rd_data at clock %0d", k), 32'(a_rd[k]), 32'(din));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog all requirements actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "cs_o", 32'(cs_o), 0);
    chk("R1", "we_o", 32'(we_o), 0);
    chk("R1", "re_o", 32'(re_o), 0);
    chk("R1", "dc_o", 32'(dc_o), 0);
    chk("R1", "sample_o", 32'(sample_o), 0);
    chk("R1", "done_o", 32'(done_o), 0);
    chk("R1", "cfg_err", 32'(cfg_err), 0);
    chk("R1", "rd_data", 32'(rd_data), 0);

    load(1, 9, 2, 6, 3, 7, 8, 10, 2, 5, 1'b0, 4'h0, 1'b1);
    chk("R9", "cfg_err after legal load", 32'(cfg_err), 0);

    clear_plan(); sched(2, 0, 0); add_acc(2, 0, 0);
    run(28, "R2", 16'h0000);

    clear_plan(); sched(2, 1, 1); add_acc(2, 1, 1);
    run(24, "R3 R6", 16'hA5C3);

    load(1, 9, 2, 6, 3, 7, 8, 10, 2, 5, 1'b1, 4'h0, 1'b1);
    clear_plan(); sched(2, 1, 0); add_acc(2, 1, 0);
    run(34, "R4", 16'h3C96);

    load(1, 9, 2, 6, 3, 7, 8, 10, 2, 5, 1'b0, 4'hF, 1'b1);
    clear_plan(); sched(2, 0, 1); add_acc(2, 0, 1);
    run(22, "R5", 16'h0000);

    load(1, 9, 2, 6, 3, 7, 8, 10, 2, 5, 1'b0, 4'h0, 1'b1);
    clear_plan(); sched(2, 0, 0); sched(6, 1, 1); sched(8, 0, 0);
    add_acc(2, 0, 0); add_acc(13, 1, 1);
    run(34, "R7 R8", 16'h1234);

    load(1, 9, 2, 6, 3, 7, 8, 10, 1, 5, 1'b1, 4'h0, 1'b1);
    clear_plan(); sched(2, 0, 1); sched(5, 1, 0);
    add_acc(2, 0, 1); add_acc(21, 1, 0);
    run(50, "R7 R8 R4", 16'h0F0F);

    load_raw({6'd7, 4'd3, 6'd6, 4'd2, 6'd9, 4'd1},
             {6'd5, 4'b0100, 6'd2, 6'd10, 6'd8}, 1'b0, 4'h0);
    chk("R9", "cfg_err after reserved-bit load", 32'(cfg_err), 1);
    clear_plan(); sched(2, 0, 0); add_acc(2, 0, 0);
    run(26, "R9", 16'h0000);

    load(1, 9, 4, 4, 3, 7, 8, 10, 0, 5, 1'b0, 4'hF, 1'b0);
    clear_plan(); sched(2, 1, 1); add_acc(2, 1, 1);
    run(30, "R9", 16'h5A5A);

    load(0, 5, 1, 3, 1, 4, 4, 6, 0, 2, 1'b0, 4'h0, 1'b1);
    chk("R9", "cfg_err stays set after legal load", 32'(cfg_err), 1);
    clear_plan(); sched(2, 1, 1); add_acc(2, 1, 1);
    run(16, "R10", 16'hBEEF);

    load(15, 40, 14, 30, 13, 35, 33, 45, 0, 20, 1'b0, 4'h0, 1'b1);
    clear_plan(); sched(2, 1, 0); add_acc(2, 1, 0);
    run(56, "R10", 16'hC0DE);
    clear_plan(); sched(2, 0, 1); add_acc(2, 0, 1);
    run(44, "R10 R2", 16'h0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule